// File: doc/BRIEF.md
# Pseudo-Random Replacement Index Generator

This block picks a translation-table entry to evict when no better choice exists. On each accepted request it returns one index between the wired boundary and the last entry. Entries below the wired boundary are never chosen. The same index never comes back twice in a row. A 32-bit linear congruential generator supplies the randomness. The upper half of its state is reduced modulo the pickable range by a bit-serial remainder unit. A candidate that equals the previous pick is thrown away and the generator steps again, so the time to a result varies.

Requests use a valid/ready handshake. `req_ready` is high only when the block is idle and is not presenting a result. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. While a search runs, `req_ready` stays low, and `req_valid` is ignored. The result side has no back-pressure. `rsp_valid` is a single-cycle pulse, and `rsp_idx` keeps its value until the next result replaces it. `entries` and `wired` are captured when the request is accepted. `wired` must be below `entries`.

Top module: `rnd_repl_idx`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `rsp_valid` is 0 and `rsp_idx` is 0.
- R2: The generator state is 32 bits and is set to 1 by reset. Each step computes state = state * 1103515245 + 12345 and keeps the low 32 bits. A candidate is (state >> 16) mod (entries - wired) + wired, taken from the state after the step.
- R3: When entries - wired equals 1, the result is entries - 1. The generator does not step in that case, and the stored previous pick is left unchanged.
- R4: A candidate equal to the stored previous pick is rejected, and the generator steps again until a candidate differs. The result that is finally returned then becomes the stored previous pick.
- R5: Reset sets the stored previous pick to 0 and the generator state to 1, both together. Right after reset, a request with entries=2 and wired=0 returns 1, because the first candidate is 0 and is rejected.
- R6: `rsp_valid` is high for exactly one cycle per accepted request. `rsp_idx` changes only in a cycle where `rsp_valid` is high.
- R7: After an acceptance, `req_ready` stays low until the cycle after the `rsp_valid` pulse. `req_valid` has no effect while `req_ready` is low: it produces no extra result and does not step the generator.
- R8: Every returned index satisfies wired <= index <= entries - 1, using the values captured when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and can accept a request |
| entries | input | ENT_W (7) | Total entry count, 1 to MAX_ENTRIES |
| wired | input | IDX_W (6) | Number of protected low entries, less than `entries` |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_idx | output | IDX_W (6) | Chosen index, held between results |

## Verification
The hardest path to reach from the ports is the repeat-rejection retry, because it only fires when the reduced generator output happens to match the previous pick. The bench forces it at once after reset with a two-entry range, where the first candidate is 0 and matches the reset value of the previous pick. It then runs long random sequences over narrow ranges, where collisions are frequent. Requests raised while a search is running are checked to leave the next expected index unchanged. A reset in the middle of a sequence is checked to replay the sequence from its start.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  localparam int unsigned LCG_MUL = 32'd1103515245;
  localparam int unsigned LCG_ADD = 32'd12345;
  localparam int unsigned LCG_SEED = 32'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } pick_st_e;
endpackage

// File: rtl/rnd_lcg_step.sv
module rnd_lcg_step #(
  parameter int STATE_W = 32
) (
  input  logic [STATE_W-1:0] cur,
  output logic [STATE_W-1:0] nxt
);
  logic [STATE_W-1:0] prod;
  always_comb begin
    prod = cur * STATE_W'(rnd_pkg::LCG_MUL);
    nxt  = prod + STATE_W'(rnd_pkg::LCG_ADD);
  end
endmodule

// File: rtl/rnd_mod_unit.sv
module rnd_mod_unit #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVS_W-1:0] rem
);
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam int REM_W = DVS_W + 1;

  logic [DVD_W-1:0] sr_q;
  logic [REM_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [REM_W-1:0] shifted;
  logic [REM_W-1:0] trial;

  always_comb begin
    shifted = {rem_q[REM_W-2:0], sr_q[DVD_W-1]};
    trial   = (shifted >= {1'b0, dvs_q}) ? shifted - {1'b0, dvs_q} : shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      sr_q   <= dividend;
      rem_q  <= '0;
      dvs_q  <= divisor;
      cnt_q  <= CNT_W'(DVD_W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        sr_q  <= {sr_q[DVD_W-2:0], 1'b0};
        rem_q <= trial;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign done = busy_q && (cnt_q == '0);
  assign rem  = rem_q[DVS_W-1:0];
endmodule

// File: rtl/rnd_repl_idx.sv
module rnd_repl_idx #(
  parameter int MAX_ENTRIES = 64,
  parameter int STATE_W     = 32,
  parameter int ENT_W       = $clog2(MAX_ENTRIES + 1),
  parameter int IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ENT_W-1:0] entries,
  input  logic [IDX_W-1:0] wired,
  output logic             rsp_valid,
  output logic [IDX_W-1:0] rsp_idx
);
  import rnd_pkg::*;

  localparam int HALF_W = STATE_W / 2;

  pick_st_e           st_q;
  logic [STATE_W-1:0] lcg_q;
  logic [STATE_W-1:0] lcg_nxt;
  logic [IDX_W-1:0]   prev_q;
  logic [IDX_W-1:0]   wired_q;
  logic [ENT_W-1:0]   span_q;
  logic [ENT_W-1:0]   span_in;
  logic               accept;
  logic               mod_start;
  logic               mod_done;
  logic [ENT_W-1:0]   mod_rem;
  logic [IDX_W-1:0]   cand;

  rnd_lcg_step #(.STATE_W(STATE_W)) lcg_i (
    .cur (lcg_q),
    .nxt (lcg_nxt)
  );

  rnd_mod_unit #(.DVD_W(HALF_W), .DVS_W(ENT_W)) mod_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (mod_start),
    .dividend (lcg_q[STATE_W-1:HALF_W]),
    .divisor  (span_q),
    .done     (mod_done),
    .rem      (mod_rem)
  );

  assign req_ready = (st_q == ST_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign span_in   = entries - ENT_W'(wired);
  assign mod_start = (st_q == ST_START);
  assign cand      = mod_rem[IDX_W-1:0] + wired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      lcg_q     <= STATE_W'(LCG_SEED);
      prev_q    <= '0;
      wired_q   <= '0;
      span_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            wired_q <= wired;
            span_q  <= span_in;
            if (span_in == ENT_W'(1)) begin
              rsp_idx   <= IDX_W'(entries - ENT_W'(1));
              rsp_valid <= 1'b1;
            end else begin
              lcg_q <= lcg_nxt;
              st_q  <= ST_START;
            end
          end
        end
        ST_START: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (mod_done) begin
            if (cand == prev_q) begin
              lcg_q <= lcg_nxt;
              st_q  <= ST_START;
            end else begin
              prev_q    <= cand;
              rsp_idx   <= cand;
              rsp_valid <= 1'b1;
              st_q      <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rnd_repl_idx_chk.sv
module rnd_repl_idx_chk #(
  parameter int ENT_W = 7,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ENT_W-1:0] entries,
  input logic [IDX_W-1:0] wired,
  input logic             rsp_valid,
  input logic [IDX_W-1:0] rsp_idx
);
  logic [ENT_W-1:0] c_ent;
  logic [IDX_W-1:0] c_wir;
  logic [IDX_W-1:0] c_last;
  logic             c_single;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_ent    <= '0;
      c_wir    <= '0;
      c_last   <= '0;
      c_single <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        c_ent    <= entries;
        c_wir    <= wired;
        c_single <= (entries - ENT_W'(wired)) == ENT_W'(1);
      end
      if (rsp_valid && !c_single) c_last <= rsp_idx;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_idx));
  // R7
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_idx >= c_wir) && (ENT_W'(rsp_idx) < c_ent));
  // R4
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !c_single) |-> (rsp_idx != c_last));
  // R3
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && c_single) |-> (ENT_W'(rsp_idx) == c_ent - ENT_W'(1)));
endmodule

bind rnd_repl_idx rnd_repl_idx_chk #(.ENT_W(ENT_W), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .entries   (entries),
  .wired     (wired),
  .rsp_valid (rsp_valid),
  .rsp_idx   (rsp_idx)
);

// File: tb/rnd_repl_idx_tb_top.sv
`timescale 1ns/1ps
module rnd_repl_idx_tb_top;
  localparam int ENT_W = 7;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ENT_W-1:0] entries = '0;
  logic [IDX_W-1:0] wired = '0;
  logic             rsp_valid;
  logic [IDX_W-1:0] rsp_idx;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  bit done_flag = 1'b0;

  logic [31:0]      m_state;
  logic [IDX_W-1:0] m_prev;

  always #2.5 clk = ~clk;

  rnd_repl_idx dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .entries(entries), .wired(wired), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx)
  );

  always @(posedge clk) if (rsp_valid) vcount <= vcount + 1;

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_pick(input int ent, input int wir);
    int rng = ent - wir;
    int cand;
    if (rng == 1) return ent - 1;
    do begin
      m_state = lcg(m_state);
      cand = int'(m_state[31:16]) % rng + wir;
    end while (cand == int'(m_prev));
    m_prev = IDX_W'(cand);
    return cand;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_state = 32'd1;
    m_prev = '0;
    @(negedge clk);
  endtask

  task automatic wait_rsp(input string req, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (rsp_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk({req, " timeout"}, 0, 1);
  endtask

  task automatic pick(input int ent, input int wir, input string req, input bit poke_busy);
    int exp;
    int v0;
    bit ok;
    chk("R7 ready before request", int'(req_ready), 1);
    entries = ENT_W'(ent);
    wired = IDX_W'(wir);
    req_valid = 1'b1;
    v0 = vcount;
    @(negedge clk);
    req_valid = 1'b0;
    exp = model_pick(ent, wir);
    if (poke_busy && !rsp_valid) begin
      // R7: a request raised while busy must be ignored
      chk("R7 ready low while busy", int'(req_ready), 0);
      entries = ENT_W'(64);
      wired = '0;
      req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_rsp(req, ok);
    if (ok) begin
      chk(req, int'(rsp_idx), exp);
      // R8
      checks++;
      if (int'(rsp_idx) < wir || int'(rsp_idx) > ent - 1) begin
        errors++;
        $display("FAIL R8 actual=%0d expected=[%0d..%0d]", rsp_idx, wir, ent - 1);
      end
      @(negedge clk);
      chk("R6 valid is one cycle", int'(rsp_valid), 0);
      chk("R6 index held", int'(rsp_idx), exp);
      if (poke_busy) begin
        repeat (40) @(negedge clk);
        chk("R7 no extra result", vcount - v0, 1);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 valid after reset", int'(rsp_valid), 0);
    chk("R1 index after reset", int'(rsp_idx), 0);

    // R5: first candidate 0 equals reset previous pick -> rejected
    pick(2, 0, "R5 first pick two-entry range", 1'b0);
    chk("R5 literal result", int'(rsp_idx), 1);

    // R3: single-entry range, state and previous untouched
    pick(10, 9, "R3 single range", 1'b0);
    pick(64, 63, "R3 single range top", 1'b0);
    pick(64, 0, "R2 full range", 1'b0);
    pick(3, 2, "R3 single small", 1'b0);
    pick(2, 0, "R4 narrow range", 1'b0);
    pick(2, 0, "R4 narrow range again", 1'b0);
    pick(40, 5, "R7 busy request ignored", 1'b1);

    for (int n = 0; n < 150; n++) begin
      int ent = 2 + int'($urandom % 63);
      int wir = int'($urandom % ent);
      if (n % 5 == 0) wir = ent - 2;
      pick(ent, wir, "R2 random pick", 1'b0);
    end

    // R5: reset mid-run restores state and previous together
    do_reset();
    pick(2, 0, "R5 after second reset", 1'b0);
    chk("R5 literal after second reset", int'(rsp_idx), 1);
    pick(64, 0, "R2 sequence replay", 1'b0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule